// File: doc/BRIEF.md
# Parallel Host Port Target with Write Drain and Read Prefetch

This block is the target end of a 16-bit parallel host port that reaches a 32-bit internal memory. The host selects one of four registers with a two-bit select: a control register, a write-address register, a read-address register and a data register. The two address registers are independent. Data-register accesses move one 16-bit half of a 32-bit word at a time. A half-word indicator picks the half. Each access is either auto-increment or fixed.

Host writes collect in a small write FIFO. The FIFO drains to memory through a single-word request/grant port. Host reads are served from a read FIFO. Once a sequential read has been delivered, the read FIFO keeps fetching the following words ahead of the host. A control-register command can also preload it.

The active-low ready output holds the host in a strobe until the access can finish. The not-ready state covers four cases:
- a write is waiting for FIFO space;
- a read is waiting for a memory fetch;
- a write-address reload is waiting for the write FIFO to reach memory;
- an address or fetch change is waiting for an in-flight fetch to land.

Top module: `hpi_slave`

## Requirements
- R1: After reset, both address registers read back 0, no memory request is raised, and ready (active low) is high while no strobe is present.
- R2: Register select 1 is the write-address register and select 2 is the read-address register. Each is loaded by a host write and read back by a host read, and loading one leaves the other unchanged.
- R3: Data-register accesses use select 3. The half-word indicator at 0 carries bits 15:0 and at 1 carries bits 31:16. A write word is committed when its high half is written, combined with the low half written before it.
- R4: Up to 4 committed write words wait in the write FIFO while memory is slow. A high-half write that finds the FIFO full is held not-ready until space frees, and no word is lost.
- R5: A host write to the write-address register stays not-ready until every earlier write word is in memory.
- R6: The first data read after the read address is loaded stays not-ready until the word at that address has been fetched, and then returns that word.
- R7: In auto-increment mode, the address in use advances by one word after each high-half access. In fixed mode it stays put, so repeated fixed reads return the same word and repeated fixed writes overwrite the same word.
- R8: After a high-half auto-increment read, the block fetches following words ahead into a 4-word read FIFO, so later sequential reads complete with no not-ready cycle.
- R9: Writing the control register with bit 0 set preloads the read FIFO from the read address, so the next data read completes with no not-ready cycle.
- R10: Loading either address register discards prefetched read data. A read after reloading the read address returns the current memory contents.
- R11: The memory request stays asserted with a stable address until granted, read data is taken in the cycle after the grant, and only one memory access is in flight at a time.
- R12: A host that sees ready high while strobing keeps its strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Host access in progress |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_sel | input | 2 | Register select: 0 control, 1 write address, 2 read address, 3 data |
| host_autoinc | input | 1 | 1 = auto-increment data access, 0 = fixed |
| host_hwil | input | 1 | Half-word indicator: 0 low half, 1 high half |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdy_n | output | 1 | Active-low ready; an access completes on a clock edge with strobe high and this low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read grant |

## Verification
Several properties are checked on every cycle:
- the FIFOs never overflow or underflow;
- the memory request is held steady until it is granted;
- no new request starts while read data is returning;
- a write-address reload only completes with nothing left to drain;
- the host keeps its strobe while held.

The timing-dependent behaviour can only be shown by bench scenarios with varied grant latency. This covers stall versus no-stall on first, prefetched and preloaded reads, the full-FIFO stall, memory contents after a drain, and discard of stale prefetched data after memory changes underneath the block.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    localparam int HPI_AW = 16;
    localparam int HOST_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_WADDR = 2'd1,
        SEL_RADDR = 2'd2,
        SEL_DATA  = 2'd3
    } hpi_sel_e;

    typedef struct packed {
        logic [HPI_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } hpi_wr_t;

    function automatic logic [WORD_W-1:0] join_halves(input logic [HOST_W-1:0] hi,
                                                      input logic [HOST_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [HOST_W-1:0] pick_half(input logic [WORD_W-1:0] word,
                                                    input logic hi);
        return hi ? word[WORD_W-1:HOST_W] : word[HOST_W-1:0];
    endfunction

endpackage

// File: rtl/hpi_fifo.sv
module hpi_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);
    assign count = level;
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |-> !full);
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/hpi_mem_engine.sv
module hpi_mem_engine
    import hpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wf_valid,
    input  hpi_wr_t           wf_entry,
    output logic              wf_pop,
    input  logic              fetch_want,
    input  logic [HPI_AW-1:0] fetch_addr,
    output logic              rd_issue,
    output logic              rd_push,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_busy,
    output logic              rd_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [HPI_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic              req_q, req_we, rd_pend;
    logic [HPI_AW-1:0] req_addr;
    logic [WORD_W-1:0] req_wdata;
    logic              idle;

    assign idle     = !req_q && !rd_pend;
    assign wf_pop   = idle && wf_valid;
    assign rd_issue = idle && !wf_valid && fetch_want;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            req_we    <= 1'b0;
            rd_pend   <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            if (wf_pop) begin
                req_q     <= 1'b1;
                req_we    <= 1'b1;
                req_addr  <= wf_entry.addr;
                req_wdata <= wf_entry.data;
            end else if (rd_issue) begin
                req_q    <= 1'b1;
                req_we   <= 1'b0;
                req_addr <= fetch_addr;
            end
            if (req_q && mem_gnt) begin
                req_q   <= 1'b0;
                rd_pend <= !req_we;
            end else if (rd_pend) begin
                rd_pend <= 1'b0;
            end
        end
    end

    assign rd_push   = rd_pend;
    assign rd_word   = mem_rdata;
    assign wr_busy   = req_q && req_we;
    assign rd_busy   = (req_q && !req_we) || rd_pend;
    assign mem_req   = req_q;
    assign mem_we    = req_we;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;

    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    a_r11_one_in_flight: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && !mem_we) |=> !mem_req);

endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
    import hpi_pkg::*;
#(
    parameter int WF_DEPTH = 4,
    parameter int RF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_strobe,
    input  logic              host_rnw,
    input  logic [1:0]        host_sel,
    input  logic              host_autoinc,
    input  logic              host_hwil,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_rdy_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [HPI_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int WCW = $clog2(WF_DEPTH + 1);
    localparam int RCW = $clog2(RF_DEPTH + 1);

    hpi_sel_e          sel;
    logic [HPI_AW-1:0] waddr, raddr, fetch_addr;
    logic [HOST_W-1:0] lo_hold;
    logic              pf_en;

    logic              wf_push, wf_pop, wf_full, wf_empty;
    logic [WCW-1:0]    wf_count;
    hpi_wr_t           wf_in, wf_head;

    logic              rf_push, rf_pop, rf_flush, rf_full, rf_empty;
    logic [RCW-1:0]    rf_count;
    logic [WORD_W-1:0] rf_head, rf_in;

    logic              eng_wr_busy, eng_rd_busy, rd_issue, fetch_want, demand;
    logic              can_complete, done, fetch_cmd;

    assign sel = hpi_sel_e'(host_sel);
    assign fetch_cmd = !host_rnw && host_wdata[0];

    always_comb begin
        can_complete = 1'b1;
        unique case (sel)
            SEL_CTRL:  if (!host_rnw) can_complete = !eng_rd_busy;
            SEL_WADDR: if (!host_rnw) can_complete = wf_empty && !eng_wr_busy && !eng_rd_busy;
            SEL_RADDR: if (!host_rnw) can_complete = !eng_rd_busy;
            SEL_DATA: begin
                if (!host_rnw)
                    can_complete = !host_hwil || !wf_full;
                else if (host_hwil && !host_autoinc)
                    can_complete = !rf_empty && !eng_rd_busy;
                else
                    can_complete = !rf_empty;
            end
            default: can_complete = 1'b1;
        endcase
    end

    assign done       = host_strobe && can_complete;
    assign host_rdy_n = !done;

    assign rf_flush = done && !host_rnw && (sel == SEL_WADDR || sel == SEL_RADDR ||
                                            (sel == SEL_CTRL && fetch_cmd))
                    || (done && host_rnw && sel == SEL_DATA && host_hwil && !host_autoinc);
    assign rf_pop   = done && host_rnw && sel == SEL_DATA && host_hwil && host_autoinc;
    assign wf_push  = done && !host_rnw && sel == SEL_DATA && host_hwil;
    assign wf_in    = '{addr: waddr, data: join_halves(host_wdata, lo_hold)};

    assign demand     = host_strobe && host_rnw && sel == SEL_DATA && rf_empty;
    assign fetch_want = (pf_en || demand) && (rf_count < RCW'(RF_DEPTH)) && !rf_flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr      <= '0;
            raddr      <= '0;
            fetch_addr <= '0;
            lo_hold    <= '0;
            pf_en      <= 1'b0;
        end else begin
            if (rd_issue) fetch_addr <= fetch_addr + 1'b1;
            if (done) begin
                unique case (sel)
                    SEL_CTRL: if (fetch_cmd) begin
                        fetch_addr <= raddr;
                        pf_en      <= 1'b1;
                    end
                    SEL_WADDR: if (!host_rnw) begin
                        waddr      <= host_wdata[HPI_AW-1:0];
                        fetch_addr <= raddr;
                        pf_en      <= 1'b0;
                    end
                    SEL_RADDR: if (!host_rnw) begin
                        raddr      <= host_wdata[HPI_AW-1:0];
                        fetch_addr <= host_wdata[HPI_AW-1:0];
                        pf_en      <= 1'b0;
                    end
                    SEL_DATA: begin
                        if (!host_rnw) begin
                            if (!host_hwil)        lo_hold <= host_wdata;
                            else if (host_autoinc) waddr   <= waddr + 1'b1;
                        end else if (host_hwil) begin
                            if (host_autoinc) begin
                                raddr <= raddr + 1'b1;
                                pf_en <= 1'b1;
                            end else begin
                                fetch_addr <= raddr;
                                pf_en      <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_WADDR: host_rdata = HOST_W'(waddr);
            SEL_RADDR: host_rdata = HOST_W'(raddr);
            SEL_DATA:  host_rdata = pick_half(rf_head, host_hwil);
            default:   host_rdata = '0;
        endcase
    end

    hpi_fifo #(.WIDTH($bits(hpi_wr_t)), .DEPTH(WF_DEPTH)) u_wfifo (
        .clk   (clk),
        .rst   (rst),
        .flush (1'b0),
        .push  (wf_push),
        .din   (wf_in),
        .pop   (wf_pop),
        .dout  (wf_head),
        .count (wf_count),
        .full  (wf_full),
        .empty (wf_empty)
    );

    hpi_fifo #(.WIDTH(WORD_W), .DEPTH(RF_DEPTH)) u_rfifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rf_flush),
        .push  (rf_push),
        .din   (rf_in),
        .pop   (rf_pop),
        .dout  (rf_head),
        .count (rf_count),
        .full  (rf_full),
        .empty (rf_empty)
    );

    hpi_mem_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .wf_valid   (!wf_empty),
        .wf_entry   (wf_head),
        .wf_pop     (wf_pop),
        .fetch_want (fetch_want),
        .fetch_addr (fetch_addr),
        .rd_issue   (rd_issue),
        .rd_push    (rf_push),
        .rd_word    (rf_in),
        .wr_busy    (eng_wr_busy),
        .rd_busy    (eng_rd_busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata)
    );

    a_r12_strobe_held: assert property (@(posedge clk) disable iff (rst)
        (host_strobe && host_rdy_n) |=> host_strobe);
    a_r5_drained_on_reload: assert property (@(posedge clk) disable iff (rst)
        (done && !host_rnw && sel == SEL_WADDR) |-> (!mem_req && wf_count == '0));
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        rf_push |-> !rf_full);

endmodule

// File: tb/hpi_slave_tb.sv
`timescale 1ns/1ps
module hpi_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_strobe, host_rnw, host_autoinc, host_hwil;
    logic [1:0]  host_sel;
    logic [15:0] host_wdata, host_rdata;
    logic        host_rdy_n;
    logic        mem_req, mem_we, mem_gnt;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int lat    = 1;
    int grants = 0;
    int viol   = 0;
    bit finished = 0;

    logic [31:0] mem [256];
    logic        poke_tgl = 1'b0;
    logic        poke_seen = 1'b0;
    logic [7:0]  poke_addr;
    logic [31:0] poke_data;

    always #2 clk = ~clk;

    hpi_slave dut_i (
        .clk(clk), .rst(rst),
        .host_strobe(host_strobe), .host_rnw(host_rnw), .host_sel(host_sel),
        .host_autoinc(host_autoinc), .host_hwil(host_hwil),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy_n(host_rdy_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [7:0] i);
        return {8'h5A ^ i, i, ~i, i + 8'h11};
    endfunction

    // Memory model: variable grant latency, read data the cycle after grant
    int          wcnt = 0;
    bit          tog = 0;
    logic        g_we;
    logic [7:0]  g_addr;
    logic        prev_req = 0, prev_gnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
            mem_gnt = 1'b0; mem_rdata = '0; wcnt = 0;
            prev_req = 0; prev_gnt = 0;
        end else begin
            if (prev_req && !prev_gnt && !mem_req) viol++; // R11 dropped request
            if (poke_tgl != poke_seen) begin
                mem[poke_addr] = poke_data;
                poke_seen = poke_tgl;
            end
            if (mem_gnt) begin
                mem_gnt = 1'b0;
                if (!g_we) mem_rdata = mem[g_addr];
            end else if (mem_req) begin
                if (wcnt >= lat + int'(tog)) begin
                    mem_gnt = 1'b1;
                    g_we    = mem_we;
                    g_addr  = mem_addr[7:0];
                    if (mem_we) mem[g_addr] = mem_wdata;
                    wcnt = 0; tog = !tog; grants++;
                end else wcnt++;
            end
            prev_req = mem_req;
            prev_gnt = mem_gnt;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hacc(input logic [1:0] sel, input logic rnw, input logic am,
                        input logic hw, input logic [15:0] wd,
                        output logic [15:0] rd, output int stalls);
        @(negedge clk);
        host_sel = sel; host_rnw = rnw; host_autoinc = am; host_hwil = hw;
        host_wdata = wd; host_strobe = 1'b1;
        #1;
        stalls = 0;
        while (host_rdy_n && stalls < 5000) begin
            @(negedge clk); #1; stalls++;
        end
        if (stalls >= 5000) begin
            fails++;
            $display("FAIL access timeout actual %0d expected ready", stalls);
        end
        rd = host_rdata;
        @(negedge clk);
        host_strobe = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic am, input logic hw, input logic [15:0] wd);
        logic [15:0] d; int s;
        hacc(sel, 1'b0, am, hw, wd, d, s);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  sel;
        logic        rnw;
        logic        am;
        logic        hw;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        chk;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] s, input logic r, input logic a,
                                input logic h, input logic [15:0] w,
                                input logic [15:0] e, input logic c, input logic [3:0] q);
        return '{sel: s, rnw: r, am: a, hw: h, wd: w, exp: e, chk: c, req: q};
    endfunction

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        mk(2'd1, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 1'b0, 4'd0),
        mk(2'd3, 1'b0, 1'b1, 1'b0, 16'h1111, 16'h0000, 1'b0, 4'd0),
        mk(2'd3, 1'b0, 1'b1, 1'b1, 16'h2222, 16'h0000, 1'b0, 4'd0),
        mk(2'd3, 1'b0, 1'b1, 1'b0, 16'h3333, 16'h0000, 1'b0, 4'd0),
        mk(2'd3, 1'b0, 1'b1, 1'b1, 16'h4444, 16'h0000, 1'b0, 4'd0),
        mk(2'd1, 1'b0, 1'b0, 1'b0, 16'h0040, 16'h0000, 1'b0, 4'd0),
        mk(2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0040, 1'b1, 4'd2),  // R2
        mk(2'd2, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 1'b0, 4'd0),
        mk(2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0010, 1'b1, 4'd2),  // R2
        mk(2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0040, 1'b1, 4'd2),  // R2
        mk(2'd3, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1111, 1'b1, 4'd3),  // R3
        mk(2'd3, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h2222, 1'b1, 4'd3),  // R3
        mk(2'd3, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h3333, 1'b1, 4'd7),  // R7
        mk(2'd3, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4444, 1'b1, 4'd7)   // R7
    };

    initial begin
        logic [15:0] d, d2;
        int s, s2;
        rst = 1'b1;
        host_strobe = 0; host_rnw = 0; host_sel = 0; host_autoinc = 0;
        host_hwil = 0; host_wdata = 0; poke_addr = 0; poke_data = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;

        // R1: reset state
        chk("R1 rdy_n idle", 32'(host_rdy_n), 32'd1);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        hacc(2'd1, 1'b1, 1'b0, 1'b0, 16'h0, d, s);
        chk("R1 waddr", 32'(d), 32'h0);
        hacc(2'd2, 1'b1, 1'b0, 1'b0, 16'h0, d, s);
        chk("R1 raddr", 32'(d), 32'h0);

        // Vector walk
        foreach (VECS[i]) begin
            hacc(VECS[i].sel, VECS[i].rnw, VECS[i].am, VECS[i].hw, VECS[i].wd, d, s);
            if (VECS[i].chk) chk($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(d), 32'(VECS[i].exp));
        end
        chk("R3 word in memory", mem[8'h10], 32'h22221111);

        // R4: full write FIFO stalls the high half, nothing lost
        lat = 60;
        wr(2'd1, 1'b0, 1'b0, 16'h0020);
        for (int k = 0; k < 6; k++) begin
            hacc(2'd3, 1'b0, 1'b1, 1'b0, 16'hC000 + 16'(k), d, s);
            hacc(2'd3, 1'b0, 1'b1, 1'b1, 16'hD000 + 16'(k), d, s2);
            if (k < 5) chk($sformatf("R4 hi write %0d no stall", k), 32'(s2), 32'd0);
            else       chk("R4 hi write into full FIFO stalls", 32'(s2 > 0), 32'd1);
        end
        wr(2'd1, 1'b0, 1'b0, 16'h0000);
        for (int k = 0; k < 6; k++)
            chk($sformatf("R4 word %0d kept", k), mem[8'h20 + 8'(k)], {16'hD000 + 16'(k), 16'hC000 + 16'(k)});

        // R5: write-address reload waits for the drain
        lat = 8;
        wr(2'd1, 1'b0, 1'b0, 16'h0030);
        wr(2'd3, 1'b1, 1'b0, 16'hAAAA);
        wr(2'd3, 1'b1, 1'b1, 16'h5555);
        hacc(2'd1, 1'b0, 1'b0, 1'b0, 16'h0031, d, s);
        chk("R5 reload stalled", 32'(s > 0), 32'd1);
        chk("R5 word in memory at completion", mem[8'h30], 32'h5555AAAA);

        // R6: first read after raddr load stalls for the fetch
        lat = 3;
        wr(2'd2, 1'b0, 1'b0, 16'h0040);
        hacc(2'd3, 1'b1, 1'b1, 1'b0, 16'h0, d, s);
        chk("R6 first read stalls", 32'(s > 0), 32'd1);
        chk("R6 first read data", 32'(d), 32'(pat(8'h40) & 32'hFFFF));
        hacc(2'd3, 1'b1, 1'b1, 1'b1, 16'h0, d, s);
        chk("R3 high half", 32'(d), 32'(pat(8'h40) >> 16));

        // R8: prefetched sequential reads do not stall
        idle(40);
        for (int k = 1; k <= 4; k++) begin
            hacc(2'd3, 1'b1, 1'b1, 1'b0, 16'h0, d, s);
            hacc(2'd3, 1'b1, 1'b1, 1'b1, 16'h0, d2, s2);
            chk($sformatf("R8 word %0d stalls", k), 32'(s + s2), 32'd0);
            chk($sformatf("R8 word %0d data", k), {d2, d}, pat(8'h40 + 8'(k)));
        end
        hacc(2'd2, 1'b1, 1'b0, 1'b0, 16'h0, d, s);
        chk("R7 auto raddr advanced", 32'(d), 32'h0045);

        // R7: fixed reads and writes
        wr(2'd2, 1'b0, 1'b0, 16'h0050);
        for (int k = 0; k < 2; k++) begin
            hacc(2'd3, 1'b1, 1'b0, 1'b0, 16'h0, d, s);
            hacc(2'd3, 1'b1, 1'b0, 1'b1, 16'h0, d2, s);
            chk($sformatf("R7 fixed read %0d", k), {d2, d}, pat(8'h50));
        end
        hacc(2'd2, 1'b1, 1'b0, 1'b0, 16'h0, d, s);
        chk("R7 fixed raddr unchanged", 32'(d), 32'h0050);
        wr(2'd1, 1'b0, 1'b0, 16'h0060);
        wr(2'd3, 1'b0, 1'b0, 16'h1234);
        wr(2'd3, 1'b0, 1'b1, 16'h5678);
        wr(2'd3, 1'b0, 1'b0, 16'h9ABC);
        wr(2'd3, 1'b0, 1'b1, 16'hDEF0);
        wr(2'd1, 1'b0, 1'b0, 16'h0061);
        chk("R7 fixed write overwrote", mem[8'h60], 32'hDEF09ABC);
        chk("R7 fixed write next untouched", mem[8'h61], pat(8'h61));

        // R9: fetch command preloads
        wr(2'd2, 1'b0, 1'b0, 16'h0070);
        wr(2'd0, 1'b0, 1'b0, 16'h0001);
        idle(40);
        hacc(2'd3, 1'b1, 1'b1, 1'b0, 16'h0, d, s);
        chk("R9 preloaded read no stall", 32'(s), 32'd0);
        chk("R9 preloaded data", 32'(d), 32'(pat(8'h70) & 32'hFFFF));

        // R10: address reload discards stale prefetch
        wr(2'd2, 1'b0, 1'b0, 16'h0080);
        wr(2'd0, 1'b0, 1'b0, 16'h0001);
        idle(40);
        poke_addr = 8'h80; poke_data = 32'hDEADBEEF; poke_tgl = !poke_tgl;
        idle(2);
        wr(2'd2, 1'b0, 1'b0, 16'h0080);
        hacc(2'd3, 1'b1, 1'b1, 1'b0, 16'h0, d, s);
        hacc(2'd3, 1'b1, 1'b1, 1'b1, 16'h0, d2, s2);
        chk("R10 fresh data after reload", {d2, d}, 32'hDEADBEEF);

        // R11, R12
        idle(4); #1;
        chk("R11 request never dropped early", 32'(viol), 32'd0);
        chk("R11 grants occurred", 32'(grants > 0), 32'd1);
        chk("R12 idle not ready", 32'(host_rdy_n), 32'd1);

        finished = 1;
        summary();
        $finish;
    end

endmodule